// File: doc/BRIEF.md
# Clock Fan-out Output Divider Stage

This block is the digital back end of a phase-locked clock distribution driver. It receives an oscillator clock, which stands in for the loop's controlled oscillator, and two reference clocks. In normal operation the oscillator clocks an internal counter, and registered taps of that counter drive a fan of clock outputs: a double-rate output, a group of in-phase main outputs, one output inverted from that group, and a half-rate output. The analog loop, the phase comparison and the lock indication are not part of this block.

A bypass control replaces the oscillator with one of the two reference clocks, chosen by a select line. This gives a static test clock with no frequency range limit. In bypass the polarity of every output is the complement of its normal polarity. A frequency-select input puts an extra divide-by-two stage ahead of the counter. A change on that input is applied only when the counter wraps, so no output ever produces a shortened pulse. One active-low output-enable/reset input switches every output to high impedance and clears the output registers. Its release is synchronised to the internal clock, so the first output edges after release always come in the same phase relation. High impedance is modelled as an output value plus an enable for each output.

Top module: `clkdrv_out_stage`

## Requirements
- R1: With `pll_en` high the internal clock is `osc_clk`. With `pll_en` low it is `ref_a_clk` when `ref_sel` is 0 and `ref_b_clk` when `ref_sel` is 1. Edges on the unselected clocks do not move any output.
- R2: With `pll_en` low every output value is the complement of the value it has in normal mode for the same counter state. In particular, the cleared pattern in bypass is double=1, main=1, inverted=0, half=1.
- R3: With the divide-by-two stage off, let n be the number of internal clock edges since the enables rose, and let c = n mod 8. In normal polarity the double-rate output is c bit 0, the main outputs are c bit 1 and the half-rate output is c bit 2.
- R4: With `freq_sel` high when reset is released, each counter step takes two internal edges, so c = floor(n/2) mod 8.
- R5: A change of `freq_sel` while running takes effect only on the edge where the counter wraps from 7 to 0. The new rate applies from the next edge on.
- R6: All main outputs carry the same value and the same enable. The inverted output is always the complement of the main outputs.
- R7: When `oe_rst_n` is low, all enables are low after the second internal edge. From the third internal edge the outputs hold the cleared pattern (normal: double=0, main=0, inverted=1, half=0).
- R8: After `oe_rst_n` goes high, the enables rise after the second internal edge, with the outputs still in the cleared pattern. The first counter step appears on the next edge.
- R9: While enabled, the main outputs change only on an edge where the double-rate output also changes. The half-rate output changes only on an edge where the main outputs also change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock used in normal mode |
| ref_a_clk | input | 1 | First reference clock |
| ref_b_clk | input | 1 | Second reference clock |
| ref_sel | input | 1 | Reference choice: 0 selects ref_a_clk, 1 selects ref_b_clk |
| pll_en | input | 1 | High: oscillator drives the outputs; low: bypass test mode |
| freq_sel | input | 1 | High: extra divide-by-two ahead of the counter |
| oe_rst_n | input | 1 | Active-low output enable and register clear |
| dbl_out | output | 1 | Double-rate output value |
| dbl_oe | output | 1 | Double-rate output enable |
| q_out | output | NUM_Q | In-phase main output values |
| q_oe | output | NUM_Q | Main output enables |
| qn_out | output | 1 | Inverted main output value |
| qn_oe | output | 1 | Inverted output enable |
| half_out | output | 1 | Half-rate output value |
| half_oe | output | 1 | Half-rate output enable |

## Verification
The bench uses the default parameters: five main outputs and a two-stage release synchroniser. With these values the enable latency after a change of `oe_rst_n` is exactly two internal edges, so every expected value can be written as a function of the edge count since release. All three reference and oscillator clocks are gated copies of one bench clock. This allows the bench to stop the selected reference and see that the outputs freeze. It also allows it to change `freq_sel` in mid-count and check that the rate switches exactly at the counter wrap.

// File: rtl/clkdrv_pkg.sv
// Shared types for the clock fan-out output stage.
// Assumes the counter has exactly three taps: double, main and half rate.
package clkdrv_pkg;

    localparam int CNT_W = 3;

    typedef struct packed {
        logic half;
        logic main;
        logic dbl;
    } tap_t;

    // Maps a counter value onto the three output taps.
    function automatic tap_t taps_of(input logic [CNT_W-1:0] c);
        tap_t t;
        t.dbl  = c[0];
        t.main = c[1];
        t.half = c[2];
        return t;
    endfunction

endpackage

// File: rtl/clkdrv_clk_mux.sv
// Chooses the clock that runs the output stage.
// Assumes the inputs are switched only while the stage is held cleared,
// or while the clocks involved are low.
module clkdrv_clk_mux (
    input  logic osc_clk,
    input  logic ref_a_clk,
    input  logic ref_b_clk,
    input  logic ref_sel,
    input  logic pll_en,
    output logic core_clk
);

    logic ref_clk;

    // Picks the reference, then picks between the oscillator and that reference.
    always_comb begin
        ref_clk  = ref_sel ? ref_b_clk : ref_a_clk;
        core_clk = pll_en ? osc_clk : ref_clk;
    end

endmodule

// File: rtl/clkdrv_rst_sync.sv
// Brings the external enable/clear level into the internal clock domain.
// Assumes STAGES >= 2. Both assertion and release take STAGES edges.
module clkdrv_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din_n,
    output logic run
);

    logic [STAGES-1:0] chain;

    // Shifts the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], din_n};
    end

    assign run = chain[STAGES-1];

endmodule

// File: rtl/clkdrv_rate_div.sv
// Optional divide-by-two prescaler followed by the tap counter.
// The prescale choice is sampled while cleared and again only at the
// counter wrap, so a rate change never shortens an output pulse.
module clkdrv_rate_div
    import clkdrv_pkg::*;
(
    input  logic             clk,
    input  logic             run,
    input  logic             freq_sel,
    output logic [CNT_W-1:0] cnt_nxt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic             pre;
    logic             div2_q;
    logic             step;

    // Decides whether this edge advances the counter.
    always_comb begin
        step    = !div2_q || pre;
        cnt_nxt = !run ? '0 : (step ? cnt + 1'b1 : cnt);
    end

    // Holds the counter, the prescaler phase and the active rate choice.
    always_ff @(posedge clk) begin
        if (!run) begin
            cnt    <= '0;
            pre    <= 1'b0;
            div2_q <= freq_sel;
        end else begin
            cnt <= cnt_nxt;
            pre <= div2_q ? ~pre : 1'b0;
            if (step && cnt == CNT_MAX) begin
                div2_q <= freq_sel;
            end
        end
    end

endmodule

// File: rtl/clkdrv_out_regs.sv
// Output registers with per-output value and enable.
// Each main output has its own flop. The polarity flip for bypass is
// applied at the register input, so every output stays registered.
module clkdrv_out_regs
    import clkdrv_pkg::*;
#(
    parameter int NUM_Q = 5
) (
    input  logic             clk,
    input  logic             run,
    input  logic             inv,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             dbl_out,
    output logic             dbl_oe,
    output logic [NUM_Q-1:0] q_out,
    output logic [NUM_Q-1:0] q_oe,
    output logic             qn_out,
    output logic             qn_oe,
    output logic             half_out,
    output logic             half_oe
);

    tap_t nxt;
    logic qn_r;

    // Derives the next tap values, or all zero while cleared.
    always_comb begin
        nxt = run ? taps_of(cnt_nxt) : '0;
    end

    // Registers the double-rate, half-rate and inverted outputs.
    always_ff @(posedge clk) begin
        dbl_out  <= nxt.dbl ^ inv;
        half_out <= nxt.half ^ inv;
        qn_r     <= ~(nxt.main ^ inv);
    end

    for (genvar i = 0; i < NUM_Q; i++) begin : g_main
        // One register per in-phase main output.
        always_ff @(posedge clk) begin
            q_out[i] <= nxt.main ^ inv;
        end
        assign q_oe[i] = run;
    end

    assign qn_out  = qn_r;
    assign dbl_oe  = run;
    assign qn_oe   = run;
    assign half_oe = run;

endmodule

// File: rtl/clkdrv_out_stage.sv
// Top of the clock fan-out output stage: clock choice, release
// synchroniser, rate divider and output registers.
// Assumes the controls are static apart from freq_sel and oe_rst_n.
module clkdrv_out_stage
    import clkdrv_pkg::*;
#(
    parameter int NUM_Q       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             ref_a_clk,
    input  logic             ref_b_clk,
    input  logic             ref_sel,
    input  logic             pll_en,
    input  logic             freq_sel,
    input  logic             oe_rst_n,
    output logic             dbl_out,
    output logic             dbl_oe,
    output logic [NUM_Q-1:0] q_out,
    output logic [NUM_Q-1:0] q_oe,
    output logic             qn_out,
    output logic             qn_oe,
    output logic             half_out,
    output logic             half_oe
);

    logic             core_clk;
    logic             run;
    logic [CNT_W-1:0] cnt_nxt;

    clkdrv_clk_mux u_mux (
        .osc_clk   (osc_clk),
        .ref_a_clk (ref_a_clk),
        .ref_b_clk (ref_b_clk),
        .ref_sel   (ref_sel),
        .pll_en    (pll_en),
        .core_clk  (core_clk)
    );

    clkdrv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (core_clk),
        .din_n (oe_rst_n),
        .run   (run)
    );

    clkdrv_rate_div u_div (
        .clk      (core_clk),
        .run      (run),
        .freq_sel (freq_sel),
        .cnt_nxt  (cnt_nxt)
    );

    clkdrv_out_regs #(.NUM_Q(NUM_Q)) u_out (
        .clk      (core_clk),
        .run      (run),
        .inv      (~pll_en),
        .cnt_nxt  (cnt_nxt),
        .dbl_out  (dbl_out),
        .dbl_oe   (dbl_oe),
        .q_out    (q_out),
        .q_oe     (q_oe),
        .qn_out   (qn_out),
        .qn_oe    (qn_oe),
        .half_out (half_out),
        .half_oe  (half_oe)
    );

endmodule

// File: rtl/clkdrv_out_chk.sv
// Checker bound to the output stage. It is clocked by the internal clock
// and stays disarmed for the first edges after time zero.
module clkdrv_out_chk #(
    parameter int NUM_Q = 5
) (
    input logic             ck,
    input logic             pll_en,
    input logic             oe_rst_n,
    input logic             dbl_out,
    input logic             dbl_oe,
    input logic [NUM_Q-1:0] q_out,
    input logic [NUM_Q-1:0] q_oe,
    input logic             qn_out,
    input logic             qn_oe,
    input logic             half_out,
    input logic             half_oe
);

    logic [2:0] age = '0;
    logic       armed;

    // Counts edges since time zero, saturating at 7.
    always_ff @(posedge ck) begin
        if (age != 3'd7) age <= age + 3'd1;
    end
    assign armed = (age >= 3'd4);

    assert_inphase_R6: assert property (@(posedge ck) disable iff (!armed)
        (q_out == {NUM_Q{q_out[0]}}) && (q_oe == {NUM_Q{dbl_oe}}));

    assert_qn_R6: assert property (@(posedge ck) disable iff (!armed)
        (qn_out == ~q_out[0]) && (qn_oe == q_oe[0]));

    assert_oe_match_R7: assert property (@(posedge ck) disable iff (!armed)
        (half_oe == dbl_oe) && (qn_oe == dbl_oe));

    assert_oe_drop_R7: assert property (@(posedge ck) disable iff (!armed)
        (!oe_rst_n && !$past(oe_rst_n)) |=> !dbl_oe);

    assert_clear_R7: assert property (@(posedge ck) disable iff (!armed)
        (!dbl_oe && !$past(dbl_oe)) |->
        (dbl_out == !$past(pll_en) && half_out == !$past(pll_en)
         && q_out[0] == !$past(pll_en)));

    assert_oe_rise_R8: assert property (@(posedge ck) disable iff (!armed)
        $rose(dbl_oe) |-> $past(oe_rst_n, 2));

    assert_qstep_R9: assert property (@(posedge ck) disable iff (!armed)
        (dbl_oe && $past(dbl_oe) && !$stable(q_out[0])) |-> !$stable(dbl_out));

    assert_halfstep_R9: assert property (@(posedge ck) disable iff (!armed)
        (dbl_oe && $past(dbl_oe) && !$stable(half_out)) |-> !$stable(q_out[0]));

endmodule

bind clkdrv_out_stage clkdrv_out_chk #(.NUM_Q(NUM_Q)) u_chk (
    .ck       (core_clk),
    .pll_en   (pll_en),
    .oe_rst_n (oe_rst_n),
    .dbl_out  (dbl_out),
    .dbl_oe   (dbl_oe),
    .q_out    (q_out),
    .q_oe     (q_oe),
    .qn_out   (qn_out),
    .qn_oe    (qn_oe),
    .half_out (half_out),
    .half_oe  (half_oe)
);

// File: tb/tb_clkdrv_out_stage.sv
module tb_clkdrv_out_stage;

    localparam int CLK_PERIOD = 10;
    localparam int NQ         = 5;

    logic clk = 1'b0;
    logic gate_a = 1'b1;
    logic gate_b = 1'b1;
    logic ref_sel = 1'b0;
    logic pll_en = 1'b1;
    logic freq_sel = 1'b0;
    logic oe_rst_n = 1'b0;

    logic          dbl_out, dbl_oe, qn_out, qn_oe, half_out, half_oe;
    logic [NQ-1:0] q_out, q_oe;
    logic          ref_a_clk, ref_b_clk;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ref_a_clk = clk & gate_a;
    assign ref_b_clk = clk & gate_b;

    clkdrv_out_stage dut (
        .osc_clk   (clk),
        .ref_a_clk (ref_a_clk),
        .ref_b_clk (ref_b_clk),
        .ref_sel   (ref_sel),
        .pll_en    (pll_en),
        .freq_sel  (freq_sel),
        .oe_rst_n  (oe_rst_n),
        .dbl_out   (dbl_out),
        .dbl_oe    (dbl_oe),
        .q_out     (q_out),
        .q_oe      (q_oe),
        .qn_out    (qn_out),
        .qn_oe     (qn_oe),
        .half_out  (half_out),
        .half_oe   (half_oe)
    );

    // Waits k bench clock edges and lands on the following falling edge.
    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    // Compares the outputs with counter value c at polarity inv.
    task automatic check_pattern(input int c, input logic inv, input string tag);
        logic [3:0] exp_v, act_v;
        logic       eq;
        exp_v = {c[0] ^ inv, c[1] ^ inv, ~(c[1] ^ inv), c[2] ^ inv};
        act_v = {dbl_out, q_out[0], qn_out, half_out};
        eq = (q_out == {NQ{q_out[0]}});
        checks++;
        if (act_v !== exp_v || !eq) begin
            errors++;
            $display("FAIL %s: dbl/q/qn/half=%b q_all=%b expected %b (count %0d)",
                     tag, act_v, q_out, exp_v, c);
        end
    endtask

    // Compares every enable with the expected level.
    task automatic check_oe(input logic exp_en, input string tag);
        logic [NQ+2:0] act;
        act = {dbl_oe, q_oe, qn_oe, half_oe};
        checks++;
        if (act !== {(NQ+3){exp_en}}) begin
            errors++;
            $display("FAIL %s: enables=%b expected all %b", tag, act, exp_en);
        end
    endtask

    // Drives oe_rst_n low and lets the clear settle.
    task automatic hold_clear();
        oe_rst_n = 1'b0;
        edges(4);
    endtask

    // Releases the clear and checks the two-edge latency (R8).
    task automatic release_check(input logic inv);
        oe_rst_n = 1'b1;
        edges(1);
        check_oe(1'b0, "R8 enables low one edge after release");
        edges(1);
        check_oe(1'b1, "R8 enables high two edges after release");
        check_pattern(0, inv, "R8 cleared pattern at enable");
    endtask

    task automatic test_reset_state();
        edges(4);
        check_oe(1'b0, "R7 enables low in clear");
        check_pattern(0, 1'b0, "R7 cleared pattern normal");
    endtask

    task automatic test_div1();
        release_check(1'b0);
        for (int n = 1; n <= 16; n++) begin
            edges(1);
            check_pattern(n % 8, 1'b0, "R3 divide-by-one sequence");
        end
    endtask

    task automatic test_oe_midrun();
        oe_rst_n = 1'b0;
        edges(1);
        check_oe(1'b1, "R7 enables still high after one edge");
        edges(1);
        check_oe(1'b0, "R7 enables low after two edges");
        edges(1);
        check_pattern(0, 1'b0, "R7 registers cleared");
    endtask

    task automatic test_div2();
        hold_clear();
        freq_sel = 1'b1;
        edges(2);
        release_check(1'b0);
        for (int n = 1; n <= 20; n++) begin
            edges(1);
            check_pattern((n / 2) % 8, 1'b0, "R4 divide-by-two sequence");
        end
    endtask

    task automatic test_fs_switch();
        hold_clear();
        freq_sel = 1'b0;
        edges(2);
        release_check(1'b0);
        for (int n = 1; n <= 3; n++) begin
            edges(1);
            check_pattern(n, 1'b0, "R5 before switch");
        end
        freq_sel = 1'b1;
        for (int n = 4; n <= 22; n++) begin
            edges(1);
            if (n < 8) check_pattern(n, 1'b0, "R5 old rate until wrap");
            else       check_pattern(((n - 8) / 2) % 8, 1'b0, "R5 new rate after wrap");
        end
    endtask

    task automatic test_bypass_a();
        hold_clear();
        freq_sel = 1'b0;
        pll_en   = 1'b0;
        ref_sel  = 1'b0;
        gate_b   = 1'b0;
        edges(3);
        check_pattern(0, 1'b1, "R2 cleared pattern inverted in bypass");
        release_check(1'b1);
        for (int n = 1; n <= 10; n++) begin
            edges(1);
            check_pattern(n % 8, 1'b1, "R1 R2 bypass on ref a");
        end
    endtask

    task automatic test_bypass_b();
        hold_clear();
        ref_sel = 1'b1;
        gate_a  = 1'b0;
        gate_b  = 1'b1;
        edges(3);
        release_check(1'b1);
        for (int n = 1; n <= 10; n++) begin
            edges(1);
            check_pattern(n % 8, 1'b1, "R1 bypass on ref b");
        end
        gate_b = 1'b0;
        edges(4);
        check_pattern(10 % 8, 1'b1, "R1 outputs frozen with selected ref stopped");
        gate_b = 1'b1;
        edges(1);
        check_pattern(11 % 8, 1'b1, "R1 resumes with selected ref");
    endtask

    initial begin
        test_reset_state();
        test_div1();
        test_oe_midrun();
        test_div2();
        test_fs_switch();
        test_bypass_a();
        test_bypass_b();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule